// File: doc/BRIEF.md
# Self-Test Completion Snooper

This block watches the two byte streams between a host-side command interface and a security engine. It never touches the traffic. It does not store packets. It does not execute anything. It decodes the fixed-size header of each request as the bytes pass, and it keeps one bit that records whether that request asked the engine to continue its self-test. It then decodes the header of the response that follows. If that response carries a complete header whose return code is zero, the block emits a single-cycle `selftest_done` pulse.

A surrounding status block uses the pulse to set a sticky "self-test passed" flag. Headers are ten bytes in both directions. Bytes 0-1 hold a tag, bytes 2-5 hold a size, and bytes 6-9 hold a 32-bit word sent most significant byte first. In a request that word is the command code. In a response it is the return code. Bytes past the header are ignored.

Top module: `selftest_snoop`

## Requirements
- R1: While reset is asserted and after its release, `selftest_done` is low, and no request is considered outstanding.
- R2: A request counts as a self-test request only when request bytes 6,7,8,9 read, most significant byte first, as 32'h00000053. The byte-swapped value 32'h53000000 and other codes such as 32'h00000052 do not count.
- R3: A request that ends before its tenth byte is never a self-test request, even if the bytes it does carry at positions 6 and up match the leading bytes of the code.
- R4: A response reports success only when its bytes 6..9 read as 32'h00000000 (most significant byte first). Any nonzero code, such as 32'h00000001 or 32'h01000000, gives no pulse.
- R5: A response shorter than ten bytes never gives a pulse.
- R6: The pulse is high for exactly one clock, in the cycle right after the clock that carries the response's last byte.
- R7: The self-test decision is taken at the request's last byte. It is held through any idle time until the next response's last byte, and that response consumes it, so a second response produces no pulse.
- R8: A response with no outstanding request is ignored.
- R9: If the first byte of a new request arrives in the same clock as a response's last byte, no pulse is issued for that response. The new request is still decoded normally.
- R10: If a second request completes before a response arrives, the second request's decision replaces the first.
- R11: Payload bytes after the ten-byte header, in either stream, do not affect the result.
- R12: Idle cycles (valid low) inside a packet do not change byte positions or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Request byte present this cycle |
| cmd_data | input | 8 | Request byte |
| cmd_last | input | 1 | Marks the final request byte |
| rsp_valid | input | 1 | Response byte present this cycle |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Marks the final response byte |
| selftest_done | output | 1 | One-cycle pulse: self-test request completed successfully |

## Verification
Two events can land in the same clock: the final byte of a successful response, which would produce the pulse, and the opening byte of the next request, which clears it. The bench provokes this by driving the last response byte and the first byte of a new self-test request together. It expects no pulse for that response. It then sends a clean successful response and expects a pulse, which shows that the overlapping request was still decoded and latched.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  localparam int DEF_DATA_W      = 8;
  localparam int DEF_HDR_BYTES   = 10;
  localparam int DEF_FIELD_OFS   = 6;
  localparam int DEF_FIELD_BYTES = 4;
  localparam logic [31:0] DEF_SELFTEST_CODE = 32'h0000_0053;
  localparam logic [31:0] DEF_GOOD_CODE     = 32'h0000_0000;

  typedef enum logic [0:0] {
    PAIR_IDLE = 1'b0,
    PAIR_WAIT = 1'b1
  } pair_state_e;

endpackage

// File: rtl/snoop_field_grab.sv
module snoop_field_grab #(
  parameter int DATA_W      = snoop_pkg::DEF_DATA_W,
  parameter int HDR_BYTES   = snoop_pkg::DEF_HDR_BYTES,
  parameter int FIELD_OFS   = snoop_pkg::DEF_FIELD_OFS,
  parameter int FIELD_BYTES = snoop_pkg::DEF_FIELD_BYTES,
  localparam int FIELD_W    = DATA_W * FIELD_BYTES,
  localparam int CNT_W      = $clog2(HDR_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat_valid,
  input  logic [DATA_W-1:0]  beat_data,
  input  logic               beat_last,
  output logic               start_o,
  output logic               end_o,
  output logic               full_o,
  output logic [FIELD_W-1:0] field_o
);

  localparam logic [CNT_W-1:0] WIN_LO  = CNT_W'(FIELD_OFS);
  localparam logic [CNT_W-1:0] WIN_HI  = CNT_W'(FIELD_OFS + FIELD_BYTES);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HDR_BYTES - 1);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FIELD_W-1:0] fld_q, fld_d, fld_shift;
  logic               cnt_en, fld_en, in_win;

  assign in_win = (cnt_q >= WIN_LO) && (cnt_q < WIN_HI);

  generate
    if (FIELD_BYTES == 1) begin : g_single
      assign fld_shift = beat_data;
    end else begin : g_shift
      assign fld_shift = {fld_q[FIELD_W-DATA_W-1:0], beat_data};
    end
  endgenerate

  always_comb begin
    cnt_en = beat_valid;
    cnt_d  = cnt_q;
    if (beat_last) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
    fld_en = beat_valid && in_win;
    fld_d  = fld_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q <= '0;
    end else if (fld_en) begin
      fld_q <= fld_d;
    end
  end

  assign start_o = beat_valid && (cnt_q == '0);
  assign end_o   = beat_valid && beat_last;
  assign full_o  = (cnt_q >= LAST_HDR);
  assign field_o = fld_en ? fld_d : fld_q;

  assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  assert_cnt_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_last) |=> (cnt_q == '0));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |=> $stable(cnt_q));

endmodule

// File: rtl/snoop_pair_ctrl.sv
module snoop_pair_ctrl #(
  parameter int FIELD_W = 32,
  parameter logic [FIELD_W-1:0] MATCH_CODE = FIELD_W'(snoop_pkg::DEF_SELFTEST_CODE),
  parameter logic [FIELD_W-1:0] GOOD_CODE  = FIELD_W'(snoop_pkg::DEF_GOOD_CODE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_start,
  input  logic               cmd_end,
  input  logic               cmd_full,
  input  logic [FIELD_W-1:0] cmd_field,
  input  logic               rsp_end,
  input  logic               rsp_full,
  input  logic [FIELD_W-1:0] rsp_field,
  output logic               done_o
);
  import snoop_pkg::*;

  pair_state_e state_q, state_d;
  logic        sel_q, sel_d, sel_en;
  logic        done_q, done_d;
  logic        rsp_hit;

  always_comb begin
    state_d = state_q;
    sel_en  = cmd_end;
    sel_d   = cmd_full && (cmd_field == MATCH_CODE);
    rsp_hit = 1'b0;
    if (rsp_end && (state_q == PAIR_WAIT)) begin
      rsp_hit = sel_q && rsp_full && (rsp_field == GOOD_CODE);
      state_d = PAIR_IDLE;
    end
    if (cmd_end) begin
      state_d = PAIR_WAIT;
    end
    done_d = rsp_hit && !cmd_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PAIR_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign done_o = done_q;

  assert_orphan_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_end && (state_q == PAIR_IDLE)) |=> !done_q);

  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !done_q);

  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_short_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_end && !rsp_full) |=> !done_q);

  assert_bad_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_end && (rsp_field != GOOD_CODE)) |=> !done_q);

  assert_decision_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_end |=> $stable(sel_q));

endmodule

// File: rtl/selftest_snoop.sv
module selftest_snoop #(
  parameter int DATA_W      = snoop_pkg::DEF_DATA_W,
  parameter int HDR_BYTES   = snoop_pkg::DEF_HDR_BYTES,
  parameter int FIELD_OFS   = snoop_pkg::DEF_FIELD_OFS,
  parameter int FIELD_BYTES = snoop_pkg::DEF_FIELD_BYTES,
  localparam int FIELD_W    = DATA_W * FIELD_BYTES,
  parameter logic [FIELD_W-1:0] SELFTEST_CODE = FIELD_W'(snoop_pkg::DEF_SELFTEST_CODE),
  parameter logic [FIELD_W-1:0] GOOD_CODE     = FIELD_W'(snoop_pkg::DEF_GOOD_CODE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_last,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_last,
  output logic              selftest_done
);

  logic               rst_meta_q, rst_sync_q;
  logic               cmd_start, cmd_end, cmd_full;
  logic               rsp_start, rsp_end, rsp_full;
  logic [FIELD_W-1:0] cmd_field, rsp_field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  snoop_field_grab #(
    .DATA_W(DATA_W), .HDR_BYTES(HDR_BYTES),
    .FIELD_OFS(FIELD_OFS), .FIELD_BYTES(FIELD_BYTES)
  ) u_cmd_grab (
    .clk(clk), .rst_n(rst_sync_q),
    .beat_valid(cmd_valid), .beat_data(cmd_data), .beat_last(cmd_last),
    .start_o(cmd_start), .end_o(cmd_end), .full_o(cmd_full), .field_o(cmd_field)
  );

  snoop_field_grab #(
    .DATA_W(DATA_W), .HDR_BYTES(HDR_BYTES),
    .FIELD_OFS(FIELD_OFS), .FIELD_BYTES(FIELD_BYTES)
  ) u_rsp_grab (
    .clk(clk), .rst_n(rst_sync_q),
    .beat_valid(rsp_valid), .beat_data(rsp_data), .beat_last(rsp_last),
    .start_o(rsp_start), .end_o(rsp_end), .full_o(rsp_full), .field_o(rsp_field)
  );

  snoop_pair_ctrl #(
    .FIELD_W(FIELD_W), .MATCH_CODE(SELFTEST_CODE), .GOOD_CODE(GOOD_CODE)
  ) u_pair (
    .clk(clk), .rst_n(rst_sync_q),
    .cmd_start(cmd_start), .cmd_end(cmd_end), .cmd_full(cmd_full), .cmd_field(cmd_field),
    .rsp_end(rsp_end), .rsp_full(rsp_full), .rsp_field(rsp_field),
    .done_o(selftest_done)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_q |-> !selftest_done);

  assert_after_end_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    selftest_done |-> $past(rsp_valid && rsp_last));

  assert_start_unused_R11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (rsp_start && !rsp_end) |=> !selftest_done);

endmodule

// File: tb/selftest_snoop_bench.sv
module selftest_snoop_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, cmd_last, rsp_valid, rsp_last;
  logic [7:0] cmd_data, rsp_data;
  logic       selftest_done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  bit    exp_q[$];
  string tag_q[$];
  logic  saw_last = 1'b0;
  logic  prev_done = 1'b0;

  always #2 clk = ~clk;

  selftest_snoop u_selftest_snoop (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_last(cmd_last),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .selftest_done(selftest_done)
  );

  function automatic logic [7:0] hdr_byte(int i, int len, logic [31:0] word);
    logic [31:0] sz;
    sz = 32'(len);
    if (i == 0) return 8'h00;
    if (i == 1) return 8'hC1;
    if (i < 6)  return sz[8*(5-i) +: 8];
    if (i < 10) return word[8*(9-i) +: 8];
    return 8'(8'hA0 + i);
  endfunction

  task automatic send_cmd(logic [31:0] ord, int len, bit gap);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd_data = hdr_byte(i, len, ord); cmd_last = (i == len - 1);
      if (gap && (i % 3 == 1) && (i != len - 1)) begin
        @(negedge clk);
        cmd_valid = 1'b0; cmd_data = 8'hEE; cmd_last = 1'b0;
      end
    end
    @(negedge clk);
    cmd_valid = 1'b0; cmd_last = 1'b0;
  endtask

  task automatic send_rsp(logic [31:0] code, int len, bit gap, bit exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = hdr_byte(i, len, code); rsp_last = (i == len - 1);
      if (gap && (i % 3 == 1) && (i != len - 1)) begin
        @(negedge clk);
        rsp_valid = 1'b0; rsp_data = 8'hEE; rsp_last = 1'b0;
      end
    end
    @(negedge clk);
    rsp_valid = 1'b0; rsp_last = 1'b0;
  endtask

  // R9: response last byte and first byte of the next request share one clock
  task automatic overlap_case(logic [31:0] next_ord);
    exp_q.push_back(1'b0);
    tag_q.push_back("R9 overlap");
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      rsp_valid = 1'b1; rsp_data = hdr_byte(i, 10, 32'h0); rsp_last = (i == 9);
      if (i == 9) begin
        cmd_valid = 1'b1; cmd_data = hdr_byte(0, 10, next_ord); cmd_last = 1'b0;
      end
    end
    for (int j = 1; j < 10; j++) begin
      @(negedge clk);
      rsp_valid = 1'b0; rsp_last = 1'b0;
      cmd_valid = 1'b1; cmd_data = hdr_byte(j, 10, next_ord); cmd_last = (j == 9);
    end
    @(negedge clk);
    cmd_valid = 1'b0; cmd_last = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) saw_last <= rst_n && rsp_valid && rsp_last;

  // monitor: scoreboard pop on every response end
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (prev_done) begin
        checks++;
        if (selftest_done) begin
          fails++;
          $display("FAIL R6 pulse width: actual=%0b expected=0", selftest_done);
        end
      end
      if (saw_last) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R8 response end with no expectation: actual=%0b expected=none", selftest_done);
        end else begin
          bit    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          checks++;
          if (selftest_done !== e) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b", t, selftest_done, e);
          end
        end
      end else if (selftest_done) begin
        checks++; fails++;
        $display("FAIL R6 pulse outside response end: actual=1 expected=0");
      end
      prev_done = selftest_done;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL R6 watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_data = 8'h00; cmd_last = 1'b0;
    rsp_valid = 1'b0; rsp_data = 8'h00; rsp_last = 1'b0;
    idle(3);
    checks++;
    if (selftest_done !== 1'b0) begin
      fails++; $display("FAIL R1 during reset: actual=%0b expected=0", selftest_done);
    end
    rst_n = 1'b1;
    idle(4);
    checks++;
    if (selftest_done !== 1'b0) begin
      fails++; $display("FAIL R1 after reset: actual=%0b expected=0", selftest_done);
    end

    // R1/R8: response straight after reset, nothing outstanding
    send_rsp(32'h0, 10, 0, 1'b0, "R8 orphan after reset");
    // R2: matching code, good response
    send_cmd(32'h53, 10, 0);
    send_rsp(32'h0, 10, 0, 1'b1, "R2 self-test match");
    // R7: consumed, second response is orphan
    send_rsp(32'h0, 10, 0, 1'b0, "R7 second response");
    // R2: other code, byte-swapped code
    send_cmd(32'h52, 10, 0);
    send_rsp(32'h0, 10, 0, 1'b0, "R2 code 0x52");
    send_cmd(32'h5300_0000, 10, 0);
    send_rsp(32'h0, 10, 0, 1'b0, "R2 byte-swapped");
    // R3: 9-byte request
    send_cmd(32'h0000_0053, 9, 0);
    send_rsp(32'h0, 10, 0, 1'b0, "R3 short request");
    // R4: nonzero codes
    send_cmd(32'h53, 10, 0);
    send_rsp(32'h1, 10, 0, 1'b0, "R4 code 1");
    send_cmd(32'h53, 10, 0);
    send_rsp(32'h0100_0000, 10, 0, 1'b0, "R4 code MSB");
    // R5: 9-byte response of zeros
    send_cmd(32'h53, 10, 0);
    send_rsp(32'h0, 9, 0, 1'b0, "R5 short response");
    // R7: long idle between request and response
    send_cmd(32'h53, 10, 0);
    idle(40);
    send_rsp(32'h0, 10, 0, 1'b1, "R7 held through idle");
    // R10: later request replaces earlier
    send_cmd(32'h53, 10, 0);
    send_cmd(32'h54, 10, 0);
    send_rsp(32'h0, 10, 0, 1'b0, "R10 replaced by non-match");
    send_cmd(32'h54, 10, 0);
    send_cmd(32'h53, 10, 0);
    send_rsp(32'h0, 10, 0, 1'b1, "R10 replaced by match");
    // R11: long packets with payload
    send_cmd(32'h53, 16, 0);
    send_rsp(32'h0, 14, 0, 1'b1, "R11 long packets");
    // R12: idle gaps inside packets
    send_cmd(32'h53, 12, 1);
    send_rsp(32'h0, 12, 1, 1'b1, "R12 gapped packets");
    // R9: overlap suppresses, new request still decoded
    send_cmd(32'h53, 10, 0);
    overlap_case(32'h53);
    send_rsp(32'h0, 10, 0, 1'b1, "R9 request after overlap");

    idle(5);
    checks++;
    if (exp_q.size() != 0) begin
      fails++; $display("FAIL R6 unconsumed expectations: actual=%0d expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule